// File: doc/BRIEF.md
# Dual-Destination Serial Divider Loader

This block takes frequency-synthesizer settings from a three-wire serial port (data, serial clock, load strobe) and holds them in two word registers: a reference word (a 14-bit reference count and a modulus-select bit) and a main-divider word (a 7-bit swallow count and an 11-bit programmable count). All three serial wires are asynchronous to the block clock. Each wire passes through a synchronizer and is then edge-detected on the block clock.

Frames arrive most significant bit first, and the last bit of every frame is a control bit. All frames go through one shift path. The control bit sitting in the lowest position when the load strobe rises picks the destination. It also fixes how many of the preceding bits count: 15 for a reference frame and 18 for a main frame. Any older bits are ignored.

A word whose ratio is prohibited is discarded, and a sticky error flag is raised. While the load strobe is high, a fast-lock switch enable follows it, so that a loop filter can be shortened during a channel change.

Top module: `sp_serial_prog`

## Requirements
- R1: After reset the reference count reads 8, the modulus-select bit 0, the swallow count 0, the programmable count 16, and both the error flag and the fast-lock enable read 0.
- R2: Exactly one data bit enters the shift path on each rising edge of the serial clock, most significant bit first. Toggling data without a rising serial clock edge changes nothing, and bits older than the current frame length are ignored.
- R3: On a load with control bit 1 (last bit received), the 14 bits received just before the control bit become the reference count (last of them is the LSB). The bit received just before those becomes the modulus-select bit.
- R4: On a load with control bit 0, the 7 bits just before the control bit become the swallow count, and the 11 bits just before those become the programmable count, each LSB last.
- R5: A load happens only on a rising edge of the load strobe, and a strobe held high loads once. Frames clocked in while the strobe stays high are not loaded until the next rising edge.
- R6: A load into one destination leaves the other destination's outputs unchanged.
- R7: The fast-lock enable follows the load-strobe level two block-clock cycles later. Outputs updated by a load change three block-clock cycles after the strobe rises.
- R8: A reference frame with a count below 8 is not latched, and the error flag is set. A count of 8 is accepted.
- R9: A main frame with a programmable count below 16 is not latched, and the error flag is set. A count of 16 is accepted, and the swallow count takes any value 0 to 127.
- R10: A reference frame whose modulus-select bit is 1 is rejected like a prohibited ratio, so the modulus-select output stays 0.
- R11: The error flag, once set, stays set through later valid loads until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sdata_i | input | 1 | Serial data, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous; shifts on rising edge |
| sle_i | input | 1 | Load strobe, asynchronous; loads on rising edge |
| ref_div_o | output | 14 | Reference count |
| mod_sel_o | output | 1 | Modulus-select bit |
| swal_o | output | 7 | Swallow count |
| prog_o | output | 11 | Programmable count |
| fast_lock_o | output | 1 | Fast-lock switch enable |
| ratio_err_o | output | 1 | Sticky prohibited-ratio flag |

## Verification
The bench builds the block with its default widths: 14/7/11 bit fields, floors of 8 and 16, and two synchronizer stages. These make both frame lengths (16 and 19 bits) and the exact floor boundaries reachable with short serial sequences. With two stages, the 2-cycle strobe-to-enable delay and the 3-cycle strobe-to-output delay are checked exactly on every clock. Frames with extra leading bits, strobes held over later frames, and all-ones fields exercise the bit selection and the edge-only loading.

// File: rtl/sp_serial_prog_pkg.sv
package sp_serial_prog_pkg;
  typedef enum logic {FRAME_MAIN = 1'b0, FRAME_REF = 1'b1} frame_kind_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/sp_shifter.sv
module sp_shifter #(
  parameter int unsigned SR_W = 19
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sclk_s_i,
  input  logic            sdata_s_i,
  output logic [SR_W-1:0] sr_o
);
  logic            sclk_q;
  logic [SR_W-1:0] sr_q;
  logic            rise;

  assign rise = sclk_s_i & ~sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      sr_q   <= '0;
    end else begin
      sclk_q <= sclk_s_i;
      if (rise) sr_q <= {sr_q[SR_W-2:0], sdata_s_i};
    end
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/sp_loader.sv
module sp_loader
  import sp_serial_prog_pkg::*;
#(
  parameter int unsigned REF_W    = 14,
  parameter int unsigned SWAL_W   = 7,
  parameter int unsigned PROG_W   = 11,
  parameter int unsigned REF_MIN  = 8,
  parameter int unsigned PROG_MIN = 16,
  parameter int unsigned SR_W     = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              le_s_i,
  input  logic [SR_W-1:0]   sr_i,
  output logic [REF_W-1:0]  ref_div_o,
  output logic              mod_sel_o,
  output logic [SWAL_W-1:0] swal_o,
  output logic [PROG_W-1:0] prog_o,
  output logic              err_o
);
  localparam logic [REF_W-1:0]  REF_FLOOR  = REF_W'(REF_MIN);
  localparam logic [PROG_W-1:0] PROG_FLOOR = PROG_W'(PROG_MIN);
  localparam int unsigned PROG_LO = SWAL_W + 1;
  localparam int unsigned PROG_HI = SWAL_W + PROG_W;

  logic              le_q, load;
  frame_kind_e       kind;
  logic [REF_W-1:0]  ref_cand;
  logic              mod_cand;
  logic [SWAL_W-1:0] swal_cand;
  logic [PROG_W-1:0] prog_cand;
  logic              ref_ok, main_ok;

  logic [REF_W-1:0]  ref_q;
  logic              mod_q;
  logic [SWAL_W-1:0] swal_q;
  logic [PROG_W-1:0] prog_q;
  logic              err_q;

  assign load      = le_s_i & ~le_q;
  assign kind      = frame_kind_e'(sr_i[0]);
  assign ref_cand  = sr_i[REF_W:1];
  assign mod_cand  = sr_i[REF_W+1];
  assign swal_cand = sr_i[SWAL_W:1];
  assign prog_cand = sr_i[PROG_HI:PROG_LO];
  // fixed modulus: a set select bit counts as prohibited
  assign ref_ok    = (ref_cand >= REF_FLOOR) && !mod_cand;
  assign main_ok   = (prog_cand >= PROG_FLOOR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      le_q   <= 1'b0;
      ref_q  <= REF_FLOOR;
      mod_q  <= 1'b0;
      swal_q <= '0;
      prog_q <= PROG_FLOOR;
      err_q  <= 1'b0;
    end else begin
      le_q <= le_s_i;
      if (load) begin
        if (kind == FRAME_REF) begin
          if (ref_ok) begin
            ref_q <= ref_cand;
            mod_q <= mod_cand;
          end else begin
            err_q <= 1'b1;
          end
        end else begin
          if (main_ok) begin
            swal_q <= swal_cand;
            prog_q <= prog_cand;
          end else begin
            err_q <= 1'b1;
          end
        end
      end
    end
  end

  assign ref_div_o = ref_q;
  assign mod_sel_o = mod_q;
  assign swal_o    = swal_q;
  assign prog_o    = prog_q;
  assign err_o     = err_q;
endmodule

// File: rtl/sp_serial_prog.sv
module sp_serial_prog
  import sp_serial_prog_pkg::*;
#(
  parameter int unsigned REF_W       = 14,
  parameter int unsigned SWAL_W      = 7,
  parameter int unsigned PROG_W      = 11,
  parameter int unsigned REF_MIN     = 8,
  parameter int unsigned PROG_MIN    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              sclk_i,
  input  logic              sle_i,
  output logic [REF_W-1:0]  ref_div_o,
  output logic              mod_sel_o,
  output logic [SWAL_W-1:0] swal_o,
  output logic [PROG_W-1:0] prog_o,
  output logic              fast_lock_o,
  output logic              ratio_err_o
);
  localparam int unsigned REF_LEN  = REF_W + 2;
  localparam int unsigned MAIN_LEN = SWAL_W + PROG_W + 1;
  localparam int unsigned SR_W     = max_u(REF_LEN, MAIN_LEN);

  logic [2:0]      pins_s;
  logic [SR_W-1:0] sr;

  sp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdata_i, sclk_i, sle_i}),
    .q_o   (pins_s)
  );

  sp_shifter #(.SR_W(SR_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_s_i (pins_s[1]),
    .sdata_s_i(pins_s[2]),
    .sr_o     (sr)
  );

  sp_loader #(
    .REF_W(REF_W), .SWAL_W(SWAL_W), .PROG_W(PROG_W),
    .REF_MIN(REF_MIN), .PROG_MIN(PROG_MIN), .SR_W(SR_W)
  ) u_load (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .le_s_i   (pins_s[0]),
    .sr_i     (sr),
    .ref_div_o(ref_div_o),
    .mod_sel_o(mod_sel_o),
    .swal_o   (swal_o),
    .prog_o   (prog_o),
    .err_o    (ratio_err_o)
  );

  // switch enable tracks the strobe level, not its edge
  assign fast_lock_o = pins_s[0];
endmodule

// File: rtl/sp_serial_prog_chk.sv
module sp_serial_prog_chk #(
  parameter int unsigned REF_W    = 14,
  parameter int unsigned SWAL_W   = 7,
  parameter int unsigned PROG_W   = 11,
  parameter int unsigned REF_MIN  = 8,
  parameter int unsigned PROG_MIN = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [REF_W-1:0]  ref_div_o,
  input logic              mod_sel_o,
  input logic [SWAL_W-1:0] swal_o,
  input logic [PROG_W-1:0] prog_o,
  input logic              fast_lock_o,
  input logic              ratio_err_o
);
  // R8
  ref_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ref_div_o) >= REF_MIN);
  // R9
  prog_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(prog_o) >= PROG_MIN);
  // R10
  mod_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mod_sel_o);
  // R11
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_err_o |=> ratio_err_o);
  // R6
  one_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ref_div_o) |-> $stable({swal_o, prog_o}));
  // R5
  ref_on_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ref_div_o) |-> $past(fast_lock_o));
  // R5
  main_on_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({swal_o, prog_o}) |-> $past(fast_lock_o));
  // R8
  err_on_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ratio_err_o) |-> $past(fast_lock_o));
endmodule

bind sp_serial_prog sp_serial_prog_chk #(
  .REF_W(REF_W), .SWAL_W(SWAL_W), .PROG_W(PROG_W),
  .REF_MIN(REF_MIN), .PROG_MIN(PROG_MIN)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ref_div_o  (ref_div_o),
  .mod_sel_o  (mod_sel_o),
  .swal_o     (swal_o),
  .prog_o     (prog_o),
  .fast_lock_o(fast_lock_o),
  .ratio_err_o(ratio_err_o)
);

// File: tb/sim_sp_serial_prog.sv
module sim_sp_serial_prog;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sdata = 1'b0, sclk = 1'b0, sle = 1'b0;
  logic [13:0] ref_div;
  logic        mod_sel;
  logic [6:0]  swal;
  logic [10:0] prog;
  logic        fast_lock, ratio_err;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sp_serial_prog u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sdata_i(sdata), .sclk_i(sclk), .sle_i(sle),
    .ref_div_o(ref_div), .mod_sel_o(mod_sel), .swal_o(swal), .prog_o(prog),
    .fast_lock_o(fast_lock), .ratio_err_o(ratio_err)
  );

  // behavioural reference: input history, newest at back
  bit hd[$], hc[$], hl[$];
  longint m_sr;
  int m_ref, m_mod, m_swal, m_prog, m_fl, m_err;

  task automatic model_reset();
    hd = '{0, 0, 0, 0}; hc = '{0, 0, 0, 0}; hl = '{0, 0, 0, 0};
    m_sr = 0; m_ref = 8; m_mod = 0; m_swal = 0; m_prog = 16; m_fl = 0; m_err = 0;
  endtask

  task automatic model_load();
    int r, m, a, n;
    if ((m_sr & 1) == 1) begin
      r = int'((m_sr >> 1) & 14'h3fff);
      m = int'((m_sr >> 15) & 1);
      if (r >= 8 && m == 0) begin m_ref = r; m_mod = m; end
      else m_err = 1;
    end else begin
      a = int'((m_sr >> 1) & 7'h7f);
      n = int'((m_sr >> 8) & 11'h7ff);
      if (n >= 16) begin m_swal = a; m_prog = n; end
      else m_err = 1;
    end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_ni) model_reset();
    else begin
      // synchronized values seen before this edge are two samples old
      if (hl[$-1] && !hl[$-2]) model_load();
      if (hc[$-1] && !hc[$-2]) m_sr = ((m_sr << 1) | longint'(hd[$-1])) & 19'h7ffff;
      m_fl = int'(hl[$]);
      hd.push_back(sdata); void'(hd.pop_front());
      hc.push_back(sclk);  void'(hc.pop_front());
      hl.push_back(sle);   void'(hl.pop_front());
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    check("R3 ref_div", int'(ref_div), m_ref);
    check("R10 mod_sel", int'(mod_sel), m_mod);
    check("R4 swal", int'(swal), m_swal);
    check("R4 prog", int'(prog), m_prog);
    check("R7 fast_lock", int'(fast_lock), m_fl);
    check("R11 ratio_err", int'(ratio_err), m_err);
  end

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bits(longint val, int len);
    for (int i = len - 1; i >= 0; i--) begin
      sdata = val[i];
      wait_cyc(3);
      sclk = 1'b1;
      wait_cyc(3);
      sclk = 1'b0;
    end
    wait_cyc(3);
  endtask

  task automatic strobe();
    sle = 1'b1; wait_cyc(5); sle = 1'b0; wait_cyc(5);
  endtask

  function automatic longint ref_frame(int sw, int r);
    return (longint'(sw) << 15) | (longint'(r) << 1) | 1;
  endfunction

  function automatic longint main_frame(int n, int a);
    return (longint'(n) << 8) | (longint'(a) << 1);
  endfunction

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    wait_cyc(4);
    rst_ni = 1'b1;
    wait_cyc(2);
    // R1 reset state
    check("R1 ref", int'(ref_div), 8);
    check("R1 prog", int'(prog), 16);
    check("R1 swal", int'(swal), 0);
    check("R1 err", int'(ratio_err), 0);
    check("R1 fl", int'(fast_lock), 0);

    // R3 reference load, R6 main untouched
    send_bits(ref_frame(0, 1000), 16); strobe();
    check("R3 ref", int'(ref_div), 1000);
    check("R6 prog", int'(prog), 16);

    // R4 main load, R6 ref untouched
    send_bits(main_frame(500, 37), 19); strobe();
    check("R4 swal", int'(swal), 37);
    check("R4 prog", int'(prog), 500);
    check("R6 ref", int'(ref_div), 1000);

    // R2 older bits ignored, all-ones fields
    send_bits((longint'(5'b10110) << 19) | main_frame(2047, 127), 24); strobe();
    check("R2 swal", int'(swal), 127);
    check("R2 prog", int'(prog), 2047);
    check("R9 err", int'(ratio_err), 0);

    // R2 data toggles without serial clock: reload gives same word
    for (int i = 0; i < 6; i++) begin sdata = ~sdata; wait_cyc(2); end
    strobe();
    check("R2 prog", int'(prog), 2047);

    // R7 fast-lock delay
    sle = 1'b1; wait_cyc(1);
    check("R7 fl early", int'(fast_lock), 0);
    wait_cyc(1);
    check("R7 fl", int'(fast_lock), 1);
    sle = 1'b0; wait_cyc(4);

    // R8 boundary accepted then prohibited
    send_bits(ref_frame(0, 8), 16); strobe();
    check("R8 ref", int'(ref_div), 8);
    check("R8 err", int'(ratio_err), 0);
    send_bits(ref_frame(0, 7), 16); strobe();
    check("R8 ref kept", int'(ref_div), 8);
    check("R8 err", int'(ratio_err), 1);

    // R11 sticky through valid load
    send_bits(ref_frame(0, 300), 16); strobe();
    check("R11 ref", int'(ref_div), 300);
    check("R11 err", int'(ratio_err), 1);

    // R1 reset clears error
    @(negedge clk); rst_ni = 1'b0; wait_cyc(2); rst_ni = 1'b1; wait_cyc(2);
    check("R1 err", int'(ratio_err), 0);
    check("R1 ref", int'(ref_div), 8);

    // R9 boundary
    send_bits(main_frame(16, 0), 19); strobe();
    check("R9 prog", int'(prog), 16);
    check("R9 err", int'(ratio_err), 0);
    send_bits(main_frame(15, 9), 19); strobe();
    check("R9 prog kept", int'(prog), 16);
    check("R9 swal kept", int'(swal), 0);
    check("R9 err", int'(ratio_err), 1);

    // R10 modulus bit set is rejected
    send_bits(ref_frame(1, 2000), 16); strobe();
    check("R10 ref kept", int'(ref_div), 8);
    check("R10 mod", int'(mod_sel), 0);

    // R5 held strobe loads once
    send_bits(ref_frame(0, 4000), 16);
    sle = 1'b1; wait_cyc(6);
    check("R5 ref", int'(ref_div), 4000);
    send_bits(ref_frame(0, 5555), 16);
    check("R5 held", int'(ref_div), 4000);
    check("R7 fl held", int'(fast_lock), 1);
    sle = 1'b0; wait_cyc(5);
    check("R7 fl low", int'(fast_lock), 0);
    strobe();
    check("R5 reload", int'(ref_div), 5555);

    wait_cyc(4);
    finish_run();
  end
endmodule